// File: doc/BRIEF.md
# Byte-Wide Frame-Synchronous Scrambler

This block scrambles a byte-serial STS-12 stream, one byte per clock. A one-cycle frame pulse marks the first A1 byte of the frame. From that pulse a position counter finds the row-1 framing bytes, which pass through unchanged. It also finds the first byte after the last Z0 byte. At that byte a 7-stage generator with polynomial 1 + x^6 + x^7 is loaded with all ones. From then on the generator advances eight steps every clock and supplies one key byte per clock. Every later byte of the frame is XORed with that key byte.

Two static controls shape the data. The scramble enable gates the XOR, and the generator keeps running while the XOR is off. The stream enable replaces the incoming byte with all ones before scrambling. Output data and the frame pulse are registered, so both appear one cycle after their input byte. If no new pulse arrives, the counter flywheels into the next frame. A pulse that arrives early resynchronises the counter at once.

The byte classifier is a four-state machine:
- **HUNT**: the state after reset. No pulse has been seen yet, and bytes pass through unscrambled.
- **ALIGN**: the A1 and A2 bytes, positions 0 to 2N-1.
- **TRACE**: the J0 and Z0 bytes, positions 2N to 3N-1.
- **PAYLOAD**: positions 3N to the end of the frame, where scrambling applies.

The transitions are:
- **pulse**: from any state to ALIGN, at position 0.
- **align_done**: ALIGN to TRACE.
- **trace_done**: TRACE to PAYLOAD. This transition loads the generator seed.
- **frame_wrap**: PAYLOAD to ALIGN after the last byte of the frame.

Top module: `byte_frame_scrambler`

## Requirements
- R1: While reset is asserted, `data_out` is 8'h00 and `frame_out` is 0.
- R2: `frame_out` equals `frame_in` delayed by exactly one clock.
- R3: After a frame pulse, bytes at positions 0 to 35 (A1, A2, J0 and Z0 of row 1, N=12) appear on `data_out` one clock later, unscrambled.
- R4: At position 36 the generator is loaded with 7'b1111111. With all-zero input and scrambling on, that byte comes out as 8'hFE.
- R5: From position 36 to the last position (9719), each byte is XORed with the next 8 generator bits. The generator state s[6:0] outputs s[6] first, which goes to the data MSB, and the next state is {s[5:0], s[6]^s[5]}. The generator runs eight steps per byte without a break.
- R6: With `scramble_en` at 0, every byte appears on `data_out` one clock later, unchanged.
- R7: With `stream_en` at 0, the byte entering the scrambler is 8'hFF. Framing bytes come out as 8'hFF, and payload bytes come out as 8'hFF XOR key.
- R8: Before the first frame pulse after reset, no byte is scrambled.
- R9: With no further pulse, the byte after position 9719 is treated as position 0. Bypass and reseeding then repeat in the new frame.
- R10: A pulse in the middle of a frame restarts the position at 0 on that byte.
- R11: The generator advances even while `scramble_en` is 0. When scrambling resumes in mid-frame, the key matches the byte's position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_in | input | 1 | One-cycle pulse on the first A1 byte |
| data_in | input | 8 | Incoming byte |
| scramble_en | input | 1 | 1 = XOR payload bytes with the key |
| stream_en | input | 1 | 0 = force the incoming byte to 8'hFF |
| data_out | output | 8 | Registered output byte |
| frame_out | output | 1 | Frame pulse delayed to match `data_out` |

## Verification
On every cycle the assertions check four things:
- the one-cycle alignment of the frame pulse;
- the bypass of non-payload bytes;
- the all-ones fill and the pass-through when scrambling is off;
- that the counter resynchronises on a pulse and wraps at the frame boundary, and that the seed key byte is 8'hFE and the generator never reaches the all-zero state.

Only the bench scenarios can show the following:
- that the key sequence over a whole frame matches the polynomial;
- that the seed lands on exactly position 36;
- that flywheeling into a second frame reseeds correctly;
- that a mid-frame re-enable of scrambling picks up the key at the right position.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

    // Class of the byte currently on the input, as decided by the framer FSM.
    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,   // no frame pulse seen since reset
        ST_ALIGN   = 2'd1,   // A1 / A2 bytes of row 1
        ST_TRACE   = 2'd2,   // J0 / Z0 bytes of row 1
        ST_PAYLOAD = 2'd3    // everything after, scrambled
    } byte_class_e;

    // Generator width and feedback taps (1 + x^6 + x^7).
    localparam int GEN_W   = 7;
    localparam int TAP_HI  = 6;
    localparam int TAP_LO  = 5;

endpackage

// File: rtl/bfs_frame_ctrl.sv
module bfs_frame_ctrl
    import bfs_pkg::*;
#(
    parameter int STS_N    = 12,
    parameter int COLS_STS = 90,
    parameter int ROWS     = 9
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_in,
    output byte_class_e cls_o,
    output logic        seed_o
);

    localparam int FRAME_BYTES = ROWS * COLS_STS * STS_N;
    localparam int CNT_W       = $clog2(FRAME_BYTES);
    localparam logic [CNT_W-1:0] ALIGN_LAST = CNT_W'(2 * STS_N - 1);
    localparam logic [CNT_W-1:0] TRACE_LAST = CNT_W'(3 * STS_N - 1);
    localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_BYTES - 1);

    byte_class_e       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;

    // Next-state: class and position of the byte now on the input.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (frame_in) begin
            state_d = ST_ALIGN;          // transition: pulse
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_HUNT: begin
                    state_d = ST_HUNT;
                end
                ST_ALIGN: begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == ALIGN_LAST) begin
                        state_d = ST_TRACE;      // transition: align_done
                    end
                end
                ST_TRACE: begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == TRACE_LAST) begin
                        state_d = ST_PAYLOAD;    // transition: trace_done
                    end
                end
                ST_PAYLOAD: begin
                    if (cnt_q == FRAME_LAST) begin
                        state_d = ST_ALIGN;      // transition: frame_wrap
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs.
    always_comb begin
        cls_o  = state_d;
        seed_o = !frame_in && (state_q == ST_TRACE) && (state_d == ST_PAYLOAD);
    end

    // R10: a pulse always lands the framer on position 0 of the framing bytes.
    p_resync_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_in |=> (state_q == ST_ALIGN) && (cnt_q == '0));

    // R9: end of frame without a pulse wraps to position 0.
    p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_in && state_q == ST_PAYLOAD && cnt_q == FRAME_LAST)
            |=> (state_q == ST_ALIGN) && (cnt_q == '0));

    // R4: the seed falls on the byte after the last trace byte.
    p_seed_pos_r4: assert property (@(posedge clk) disable iff (!rst_n)
        seed_o |-> (cnt_q == TRACE_LAST));

    // R8: once hunting, the framer stays there until a pulse.
    p_hunt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HUNT && !frame_in) |=> (state_q == ST_HUNT));

endmodule

// File: rtl/bfs_keygen.sv
module bfs_keygen
    import bfs_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seed_i,
    input  logic              run_i,
    output logic [BYTE_W-1:0] key_o
);

    logic [GEN_W-1:0] state_q;
    logic [GEN_W-1:0] chain [0:BYTE_W];

    // Start point of the chain: the seed on the first payload byte.
    assign chain[0] = seed_i ? {GEN_W{1'b1}} : state_q;

    // One stage per key bit: bit transmitted first is the data MSB.
    for (genvar g = 0; g < BYTE_W; g++) begin : g_step
        assign key_o[BYTE_W-1-g] = chain[g][TAP_HI];
        assign chain[g+1] = {chain[g][GEN_W-2:0], chain[g][TAP_HI] ^ chain[g][TAP_LO]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= {GEN_W{1'b1}};
        end else if (run_i) begin
            state_q <= chain[BYTE_W];
        end
    end

    // R4: the first key byte after seeding is the all-ones start pattern.
    p_seed_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
        seed_i |-> (key_o[BYTE_W-1 -: 7] == 7'h7F) && (key_o[BYTE_W-8] == 1'b0));

    // R5: the generator never collapses to the all-zero lock-up state.
    p_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

    // R5: outside the payload the generator does not move.
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> $stable(state_q));

endmodule

// File: rtl/bfs_datapath.sv
module bfs_datapath #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] data_i,
    input  logic              frame_i,
    input  logic              scr_en_i,
    input  logic              strm_en_i,
    input  logic              payload_i,
    input  logic [BYTE_W-1:0] key_i,
    output logic [BYTE_W-1:0] data_o,
    output logic              frame_o
);

    logic [BYTE_W-1:0] fill;
    logic [BYTE_W-1:0] mixed;

    always_comb begin
        fill  = strm_en_i ? data_i : {BYTE_W{1'b1}};
        mixed = (scr_en_i && payload_i) ? (fill ^ key_i) : fill;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o  <= '0;
            frame_o <= 1'b0;
        end else begin
            data_o  <= mixed;
            frame_o <= frame_i;
        end
    end

    // R2: frame pulse delayed by one clock.
    p_fp_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_i |=> frame_o);
    p_fp_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_i |=> !frame_o);

    // R3: non-payload bytes bypass the XOR.
    p_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!payload_i && strm_en_i) |=> (data_o == $past(data_i)));

    // R6: with scrambling off the data is passed through.
    p_scr_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!scr_en_i && strm_en_i) |=> (data_o == $past(data_i)));

    // R7: a disabled stream presents all ones on non-scrambled bytes.
    p_fill_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!strm_en_i && (!payload_i || !scr_en_i)) |=> (data_o == {BYTE_W{1'b1}}));

endmodule

// File: rtl/byte_frame_scrambler.sv
module byte_frame_scrambler
    import bfs_pkg::*;
#(
    parameter int STS_N    = 12,
    parameter int COLS_STS = 90,
    parameter int ROWS     = 9,
    parameter int BYTE_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_in,
    input  logic [BYTE_W-1:0] data_in,
    input  logic              scramble_en,
    input  logic              stream_en,
    output logic [BYTE_W-1:0] data_out,
    output logic              frame_out
);

    byte_class_e       cls;
    logic              seed;
    logic              payload;
    logic [BYTE_W-1:0] key;

    assign payload = (cls == ST_PAYLOAD);

    bfs_frame_ctrl #(
        .STS_N    (STS_N),
        .COLS_STS (COLS_STS),
        .ROWS     (ROWS)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_in (frame_in),
        .cls_o    (cls),
        .seed_o   (seed)
    );

    bfs_keygen #(
        .BYTE_W (BYTE_W)
    ) u_key (
        .clk    (clk),
        .rst_n  (rst_n),
        .seed_i (seed),
        .run_i  (payload),
        .key_o  (key)
    );

    bfs_datapath #(
        .BYTE_W (BYTE_W)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_i    (data_in),
        .frame_i   (frame_in),
        .scr_en_i  (scramble_en),
        .strm_en_i (stream_en),
        .payload_i (payload),
        .key_i     (key),
        .data_o    (data_out),
        .frame_o   (frame_out)
    );

    // R8: before any pulse the stream is never scrambled.
    p_hunt_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == ST_HUNT && stream_en) |=> (data_out == $past(data_in)));

    // R4: seeding only happens on a payload byte.
    p_seed_payload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        seed |-> payload);

endmodule

// File: tb/tb_byte_frame_scrambler.sv
module tb_byte_frame_scrambler;

    localparam int N     = 12;
    localparam int FRAME = 9 * 90 * N;
    localparam int OHB   = 3 * N;

    // Scenario table: {scramble_en, stream_en, pattern[1:0]}
    localparam int NSCEN = 6;
    localparam logic [3:0] SCEN [0:NSCEN-1] = '{
        4'b1100, 4'b1101, 4'b1111, 4'b0110, 4'b1010, 4'b0011
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       frame_in;
    logic [7:0] data_in;
    logic       scramble_en;
    logic       stream_en;
    logic [7:0] data_out;
    logic       frame_out;

    int n_total = 0;
    int n_pass  = 0;
    int win_err = 0;
    logic [7:0] win_act, win_exp;
    logic [7:0] last_out;
    logic       last_fp;

    // Bench model state.
    logic       m_locked;
    int         m_idx;
    logic [6:0] m_key;

    always #5 clk = ~clk;

    byte_frame_scrambler dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_in    (frame_in),
        .data_in     (data_in),
        .scramble_en (scramble_en),
        .stream_en   (stream_en),
        .data_out    (data_out),
        .frame_out   (frame_out)
    );

    function automatic logic [7:0] pat(input logic [1:0] mode, input int i);
        case (mode)
            2'd0: pat = 8'(i);
            2'd1: pat = 8'h00;
            2'd2: pat = 8'hA5;
            default: pat = 8'(i * 37 + 11);
        endcase
    endfunction

    task automatic check_eq(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_total++;
        if (act === exp) n_pass++;
        else $display("FAIL %s: actual %h expected %h", tag, act, exp);
    endtask

    task automatic close_win(input string tag);
        n_total++;
        if (win_err == 0) n_pass++;
        else $display("FAIL %s: %0d mismatches, first actual %h expected %h",
                      tag, win_err, win_act, win_exp);
        win_err = 0;
    endtask

    // One byte through the design, compared against the requirement model.
    task automatic drive(input logic fp, input logic [7:0] d, input logic se, input logic sn);
        logic [7:0] e;
        logic [7:0] kb;
        @(negedge clk);
        frame_in = fp; data_in = d; scramble_en = se; stream_en = sn;
        if (fp) begin
            m_locked = 1'b1; m_idx = 0;
        end else if (m_locked) begin
            m_idx = (m_idx == FRAME - 1) ? 0 : m_idx + 1;
        end
        e = sn ? d : 8'hFF;
        if (m_locked && m_idx >= OHB) begin
            if (m_idx == OHB) m_key = 7'h7F;
            for (int b = 7; b >= 0; b--) begin
                kb[b] = m_key[6];
                m_key = {m_key[5:0], m_key[6] ^ m_key[5]};
            end
            if (se) e = e ^ kb;
        end
        @(posedge clk);
        #1;
        last_out = data_out;
        last_fp  = frame_out;
        if (data_out !== e) begin
            if (win_err == 0) begin win_act = data_out; win_exp = e; end
            win_err++;
        end
    endtask

    initial begin : watchdog
        repeat (195000) @(posedge clk);
        n_total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end

    initial begin : main
        m_locked = 1'b0; m_idx = 0; m_key = 7'h7F;
        rst_n = 1'b0; frame_in = 1'b0; data_in = 8'h5A;
        scramble_en = 1'b1; stream_en = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check_eq("R1 data_out in reset", data_out, 8'h00);
        check_eq("R1 frame_out in reset", {7'd0, frame_out}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: no pulse yet, nothing scrambled
        for (int i = 0; i < 40; i++) drive(1'b0, pat(2'd3, i), 1'b1, 1'b1);
        close_win("R8 hunt pass-through");

        // R2/R3/R4: zero data frame
        drive(1'b1, 8'h00, 1'b1, 1'b1);
        check_eq("R2 frame_out high", {7'd0, last_fp}, 8'h01);
        drive(1'b0, 8'h00, 1'b1, 1'b1);
        check_eq("R2 frame_out low", {7'd0, last_fp}, 8'h00);
        for (int i = 2; i < OHB; i++) drive(1'b0, 8'h00, 1'b1, 1'b1);
        close_win("R3 framing bytes bypass");
        drive(1'b0, 8'h00, 1'b1, 1'b1);
        check_eq("R4 first key byte", last_out, 8'hFE);
        for (int i = OHB + 1; i < FRAME; i++) drive(1'b0, 8'h00, 1'b1, 1'b1);
        close_win("R5 keystream over frame");

        // R9: flywheel into the next frame without a pulse
        for (int i = 0; i <= OHB; i++) drive(1'b0, 8'h00, 1'b1, 1'b1);
        check_eq("R9 reseed after wrap", last_out, 8'hFE);
        for (int i = OHB + 1; i < FRAME; i++) drive(1'b0, 8'h00, 1'b1, 1'b1);
        close_win("R9 flywheel frame");

        // Table-driven frames: R5 (both on), R6 (scramble off), R7 (stream off)
        for (int s = 0; s < NSCEN; s++) begin
            for (int i = 0; i < FRAME; i++)
                drive(i == 0, pat(SCEN[s][1:0], i), SCEN[s][3], SCEN[s][2]);
            if (!SCEN[s][2])      close_win("R7 stream disabled frame");
            else if (!SCEN[s][3]) close_win("R6 scramble disabled frame");
            else                  close_win("R5 scrambled frame");
        end

        // R11: scrambling off across part of the payload, then back on
        for (int i = 0; i < 2000; i++)
            drive(i == 0, pat(2'd0, i), !(i >= OHB && i < 300), 1'b1);
        close_win("R11 key position after re-enable");

        // R10: early pulse at position 500
        for (int i = 0; i < 500; i++) drive(i == 0, pat(2'd3, i), 1'b1, 1'b1);
        for (int i = 0; i <= OHB; i++) drive(i == 0, 8'h00, 1'b1, 1'b1);
        check_eq("R10 reseed after early pulse", last_out, 8'hFE);
        for (int i = 0; i < 600; i++) drive(1'b0, pat(2'd0, i), 1'b1, 1'b1);
        close_win("R10 resync stream");

        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end

endmodule